// File: doc/BRIEF.md
# External Interrupt Request Flag Capture

This block turns a set of active-low external request pins into interrupt request flags. Each source has a trigger-type bit. When the bit is 0, the source is level-sensitive: its flag follows the inverse of the pin. When the bit is 1, the source is falling-edge sensitive: a high-to-low transition on the pin sets the flag, and the flag stays set until something clears it.

The pins are brought into the clock domain through a two-stage synchronizer before any decision is made. An edge is detected as a registered high sample followed by a low sample. In edge mode a flag is cleared by either of two strobes: the per-source acknowledge from the CPU, or the per-source software clear strobe. If a new falling edge arrives in the same cycle as a clear, the new edge wins. In level mode both strobes are ignored, because the flag keeps following the pin.

Trigger-type bits are loaded through a write port. A single readback word returns the flags and the trigger-type bits. Priority, vectoring and enable masking are handled elsewhere.

Top module: `xirq_capture`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every flag is 0, every trigger-type bit is 0 (level mode) and status_rd is all zero.
- R2: A clock edge with mode_we high loads mode_wdata into the trigger-type bits. status_rd bits [2N-1:N] show the trigger-type bits (bit N+i for source i), and bits [N-1:0] show the flags (bit i for source i).
- R3: In level mode (type bit 0), irq_flag[i] equals the inverse of pin_n[i] as sampled three clock edges earlier. A pin change driven before edge k shows on the flag after edge k+2.
- R4: In level mode, flag_clr and irq_ack have no effect on a flag whose pin is held low.
- R5: In edge mode (type bit 1), a high-to-low transition of pin_n[i] sets irq_flag[i] after the third clock edge following the change. The flag stays set after the pin returns high.
- R6: In edge mode, a pin that stays low, or that rises, never sets a cleared flag.
- R7: In edge mode, an irq_ack[i] pulse clears irq_flag[i] at the next clock edge when no new falling edge is being detected.
- R8: In edge mode, a flag_clr[i] pulse clears irq_flag[i] at the next clock edge when no new falling edge is being detected.
- R9: In edge mode, a falling edge detected in the same cycle as irq_ack[i] or flag_clr[i] leaves irq_flag[i] set.
- R10: Sources are independent: pins, strobes and type bits of one source never change another source's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | NUM_SRC | Raw active-low request pins (asynchronous) |
| mode_we | input | 1 | Write strobe for the trigger-type bits |
| mode_wdata | input | NUM_SRC | Trigger-type values: 0 level, 1 falling edge |
| flag_clr | input | NUM_SRC | Per-source software clear strobe |
| irq_ack | input | NUM_SRC | Per-source interrupt acknowledge strobe |
| irq_flag | output | NUM_SRC | Interrupt request flags |
| status_rd | output | 2*NUM_SRC | Readback: {trigger-type bits, flags} |

## Verification
The assertions check these on every cycle:
- In level mode, a flag follows the synchronized pin.
- In edge mode, a detected edge sets the flag.
- In edge mode, a flag holds when no strobe is present.
- In edge mode, a strobe clears the flag when no edge is present.
- In edge mode, a flag never rises without an edge.
- A mode write shows in the readback.

Only the bench scenarios show the following:
- The three-edge latency from the raw pin.
- That clear and acknowledge leave a held-low level source untouched.
- That an edge coinciding with a strobe wins.
- That sources do not interfere with each other, across all pin transitions of both sources.

// File: rtl/xirq_pkg.sv
// Package: shared types for the external interrupt flag capture block.
// Assumes: nothing beyond IEEE 1800-2017.
package xirq_pkg;

    // Trigger type of one source; the encoding matches the type-select bit.
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/xirq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: idle inputs are high, so every stage resets to 1 and no
// false falling edge appears when reset is released.
module xirq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw asynchronous value.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= din;
            end
        end else begin : g_rest
            // Pass the value on to resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_flag_cell.sv
// Module: request flag for one source.
// Level mode: the flag follows the inverse of the synchronized pin, and
// clear/ack are ignored.
// Edge mode: the flag is set by a falling edge (registered 1 then 0) and
// cleared by clear or ack. A new edge takes priority over a clear.
// Assumes: pin_s is already synchronized to clk.
module xirq_flag_cell
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  trig_mode_e mode,
    input  logic       clr,
    input  logic       ack,
    output logic       flag
);
    logic pin_d;
    logic flag_q;
    logic fall_seen;
    logic flag_nxt;

    // Remember the previous synchronized pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b1;
        else        pin_d <= pin_s;
    end

    // Choose the next flag value from the trigger type.
    always_comb begin
        fall_seen = pin_d & ~pin_s;
        if (mode == TRIG_LEVEL) flag_nxt = ~pin_s;
        else                    flag_nxt = fall_seen | (flag_q & ~(clr | ack));
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_nxt;
    end

    assign flag = flag_q;

    AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL) |=> (flag == !$past(pin_s))); // R3
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && pin_d && !pin_s) |=> flag); // R9
    AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && flag && !clr && !ack) |=> flag); // R5
    AST_EDGE_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && (clr || ack) && !(pin_d && !pin_s)) |=> !flag); // R7
    AST_EDGE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && !flag && !(pin_d && !pin_s)) |=> !flag); // R6
endmodule

// File: rtl/xirq_capture.sv
// Module: top of the external interrupt flag capture block.
// Synchronizes the active-low pins, keeps the trigger-type bits, builds one
// flag cell per source, and returns {type bits, flags} as readback.
// Assumes: the strobes are synchronous to clk; the pins may be asynchronous.
module xirq_capture
    import xirq_pkg::*;
#(
    parameter int NUM_SRC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   pin_n,
    input  logic                 mode_we,
    input  logic [NUM_SRC-1:0]   mode_wdata,
    input  logic [NUM_SRC-1:0]   flag_clr,
    input  logic [NUM_SRC-1:0]   irq_ack,
    output logic [NUM_SRC-1:0]   irq_flag,
    output logic [2*NUM_SRC-1:0] status_rd
);
    localparam int RD_W = 2 * NUM_SRC;

    logic [NUM_SRC-1:0] pin_sync;
    logic [NUM_SRC-1:0] mode_q;
    logic [NUM_SRC-1:0] flag_w;

    xirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n),
        .dout (pin_sync)
    );

    // Trigger-type register, loaded by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        xirq_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .pin_s(pin_sync[i]),
            .mode (trig_mode_e'(mode_q[i])),
            .clr  (flag_clr[i]),
            .ack  (irq_ack[i]),
            .flag (flag_w[i])
        );
    end

    assign irq_flag  = flag_w;
    assign status_rd = RD_W'({mode_q, flag_w});

    AST_MODE_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (status_rd[RD_W-1:NUM_SRC] == $past(mode_wdata))); // R2
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(status_rd[RD_W-1:NUM_SRC])); // R2
endmodule

// File: tb/xirq_capture_test.sv
module xirq_capture_test;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_n = '1;
    logic         mode_we = 1'b0;
    logic [N-1:0] mode_wdata = '0;
    logic [N-1:0] flag_clr = '0;
    logic [N-1:0] irq_ack = '0;
    logic [N-1:0] irq_flag;
    logic [2*N-1:0] status_rd;

    int checks = 0;
    int fails  = 0;

    xirq_capture uut (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .irq_flag(irq_flag), .status_rd(status_rd)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [N-1:0] m);
        mode_we = 1'b1; mode_wdata = m;
        tick(1);
        mode_we = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        check("R1 reset state", status_rd, '0);

        // R2: sweep every type-bit pattern through the write port.
        for (int m = 0; m < 4; m++) begin
            write_mode(N'(m));
            check("R2 mode readback", {2'b00, status_rd[2*N-1:N]}, 4'(m));
        end
        write_mode('0);
        tick(4);

        // R3/R10: all transitions between pin patterns, with latency.
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                pin_n = N'(a);
                tick(4);
                pin_n = N'(b);
                tick(2);
                check("R3 flag unchanged before latency", {2'b00, irq_flag}, 4'(~a & 3));
                tick(1);
                check("R3 R10 level flag is inverted pin", {2'b00, irq_flag}, 4'(~b & 3));
                check("R2 readback flags", status_rd, 4'(~b & 3));
            end
        end

        // R4: clear and ack ignored while pins are held low in level mode.
        pin_n = '0;
        tick(4);
        flag_clr = '1; irq_ack = '1;
        tick(1);
        check("R4 strobes ignored in level mode", {2'b00, irq_flag}, 4'b0011);
        flag_clr = '0; irq_ack = '0;
        tick(1);
        check("R4 flags still set after strobes", {2'b00, irq_flag}, 4'b0011);
        pin_n = '1;
        tick(4);

        // Edge mode for both sources.
        write_mode('1);
        tick(2);
        check("R6 no flag on steady high pins", {2'b00, irq_flag}, 4'b0000);

        for (int s = 0; s < N; s++) begin
            // R5/R10: falling edge on source s only.
            pin_n[s] = 1'b0;
            tick(2);
            check("R5 no flag before third edge", {2'b00, irq_flag}, 4'b0000);
            tick(1);
            check("R5 R10 falling edge sets own flag", {2'b00, irq_flag}, 4'(1 << s));
            pin_n[s] = 1'b1;
            tick(4);
            check("R5 flag held after pin rises", {2'b00, irq_flag}, 4'(1 << s));
            // R7
            irq_ack[s] = 1'b1;
            tick(1);
            irq_ack[s] = 1'b0;
            check("R7 ack clears edge flag", {2'b00, irq_flag}, 4'b0000);
            // R8
            pin_n[s] = 1'b0;
            tick(4);
            flag_clr[s] = 1'b1;
            tick(1);
            flag_clr[s] = 1'b0;
            check("R8 software clear clears edge flag", {2'b00, irq_flag}, 4'b0000);
            // R6: pin stays low, then rises.
            tick(3);
            check("R6 steady low does not retrigger", {2'b00, irq_flag}, 4'b0000);
            pin_n[s] = 1'b1;
            tick(4);
            check("R6 rising edge does not set flag", {2'b00, irq_flag}, 4'b0000);
        end

        // R9: a new edge coinciding with ack or clear keeps the flag set.
        for (int s = 0; s < N; s++) begin
            for (int k = 0; k < 2; k++) begin
                pin_n[s] = 1'b0;
                tick(4);
                pin_n[s] = 1'b1;
                tick(4);
                pin_n[s] = 1'b0;
                tick(2);
                if (k == 0) irq_ack[s] = 1'b1; else flag_clr[s] = 1'b1;
                tick(1);
                irq_ack = '0; flag_clr = '0;
                check("R9 edge wins over coincident strobe", {2'b00, irq_flag}, 4'(1 << s));
                tick(2);
                check("R9 flag remains set", {2'b00, irq_flag}, 4'(1 << s));
                pin_n[s] = 1'b1;
                tick(4);
                irq_ack[s] = 1'b1;
                tick(1);
                irq_ack[s] = 1'b0;
                check("R7 ack clears after coincidence test", {2'b00, irq_flag}, 4'b0000);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule